// File: doc/BRIEF.md
# BCD Clock Calendar Counter Core

This block keeps wall-clock time and a calendar in packed binary-coded decimal. A free-running enable at 32,768 Hz is divided down to a one-second tick. That tick drives a cascade of fields: seconds, minutes, hours, day of week, date, month and year, plus a century flag. Each rollover ripples into the next field on the same clock edge. The length of each month is applied, and February follows a leap-year rule.

The eight timekeeping bytes sit at byte addresses 0 to 7. A host reads any byte through a combinational read port. It loads any field through a byte-wide write port. Byte 7 is plain host storage that the counters never change. For short simulations the divider ratio is a parameter.

Top module: `rtc_bcd_core`

## Requirements
- R1: Seconds advance by one after every PRESCALE clock cycles on which `osc_en` is high. Cycles with `osc_en` low do not count. The default PRESCALE is 32768.
- R2: Seconds and minutes count 0x00 to 0x59 in packed BCD, with the low digit carrying into the high digit after 9. A seconds wrap from 0x59 to 0x00 adds one minute.
- R3: Hours count 0x00 to 0x23 in bits 5:0 of byte 2. A write stores only those bits for the hour, and bit 6 always reads 0. A wrap from 23:59:59 starts a new day.
- R4: Day of week (byte 3) counts 1 to 7 and wraps to 1 on each new day.
- R5: Date (byte 4) wraps to 0x01 after the last day of the month and advances the month (byte 5). BCD months 0x04, 0x06, 0x09 and 0x11 have 30 days, and the others have 31. Month wraps from 0x12 to 0x01 and advances the year (byte 6).
- R6: February (0x02) has 29 days when the BCD year value is divisible by 4, including 0x00, and 28 days otherwise.
- R7: The year wraps from 0x99 to 0x00 and at that moment toggles the century flag, which is bit 7 of byte 2.
- R8: The read port returns the byte at `rd_addr` in the same cycle: 0 seconds, 1 minutes, 2 century/hours, 3 day, 4 date, 5 month, 6 year, 7 control. The control byte holds any 8-bit value written to it, and the tick never changes it.
- R9: A write loads its field on the next clock edge. It takes priority over a tick carry on that same edge for that field only; all other fields still update from the tick.
- R10: A write to the seconds byte restarts the divider. It also cancels any tick on that edge, so the next tick comes a full PRESCALE enabled cycles later.
- R11: After reset, seconds, minutes, hours, century, year and control read 0x00, and day, date and month read 0x01.
- R12: Every rollover in one carry chain happens on the same clock edge as the tick. For example, 23:59:59 on 0x31/0x12/0x99 becomes 00:00:00 on 0x01/0x01/0x00 in one step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_en | input | 1 | One-cycle enable at the oscillator rate |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Byte address for the write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Byte address for the read |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |

## Verification
The hardest condition to reach from the ports is a full-length carry chain. At real speed it needs a year of ticks, and the end of a century needs a hundred years. The bench shrinks the divider to four enabled cycles and preloads every field through the write port, just short of the boundary. It writes seconds last so that the divider restarts from a known phase. A single tick then exercises month-end, leap-February, year-end and century rollovers. A write that collides with a tick is staged by counting enabled cycles exactly and placing the write strobe on the same edge as the final one.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MIN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_HOUR = 3'd2;
  localparam logic [ADDR_W-1:0] A_DAY  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DATE = 3'd4;
  localparam logic [ADDR_W-1:0] A_MON  = 3'd5;
  localparam logic [ADDR_W-1:0] A_YEAR = 3'd6;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd7;

  // Next packed-BCD value, two digits.
  function automatic logic [BYTE_W-1:0] bcd_next(input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Divisible by 4: (10*tens + units) mod 4 == (2*tens + units) mod 4.
  function automatic logic bcd_leap(input logic [BYTE_W-1:0] yr);
    logic [1:0] m;
    m = yr[1:0] + {yr[4], 1'b0};
    return (m == 2'd0);
  endfunction

  // Last date of a month, as packed BCD.
  function automatic logic [BYTE_W-1:0] bcd_month_len(input logic [BYTE_W-1:0] mon,
                                                      input logic [BYTE_W-1:0] yr);
    logic [BYTE_W-1:0] r;
    case (mon)
      8'h02:                      r = bcd_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned PRESCALE = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick    = osc_en && at_last && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart)           cnt_q <= '0;
    else if (osc_en && at_last) cnt_q <= '0;
    else if (osc_en)            cnt_q <= cnt_q + 1'b1;
  end

  p_tick_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> osc_en);
  p_idle_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !restart) |=> $stable(cnt_q));
  p_restart_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
  p_restart_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !tick);

endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_pkg::*;
#(
  parameter logic [BYTE_W-1:0] LO   = 8'h00,
  parameter logic [BYTE_W-1:0] KEEP = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carry_in,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic [BYTE_W-1:0] limit,
  output logic [BYTE_W-1:0] value,
  output logic              carry_out
);
  logic [BYTE_W-1:0] val_q;
  logic              at_top;

  assign at_top    = (val_q >= limit);
  assign carry_out = carry_in && at_top;
  assign value     = val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        val_q <= LO;
    else if (load)     val_q <= load_val & KEEP;
    else if (carry_in) val_q <= at_top ? LO : bcd_next(val_q);
  end

  p_step_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_in && !load && (limit != LO)) |=> (val_q != $past(val_q)));
  p_wrap_to_lo_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_out && !load) |=> (val_q == LO));
  p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!carry_in && !load) |=> $stable(val_q));
  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (val_q == ($past(load_val) & KEEP)));

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int unsigned PRESCALE = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int unsigned NBYTES = 1 << ADDR_W;

  logic [NBYTES-1:0] wsel;
  logic              sec_tick;
  logic [BYTE_W-1:0] sec_v, min_v, hour_v, day_v, date_v, mon_v, year_v;
  logic              sec_co, min_co, day_tick, day_co, date_co, mon_co, year_co;
  logic [BYTE_W-1:0] date_last;
  logic              century_q;
  logic [BYTE_W-1:0] ctrl_q;

  for (genvar g = 0; g < NBYTES; g++) begin : g_wsel
    assign wsel[g] = wr_en && (wr_addr == ADDR_W'(g));
  end

  rtc_prescaler #(.PRESCALE(PRESCALE)) u_div (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en),
    .restart(wsel[A_SEC]), .tick(sec_tick)
  );

  rtc_bcd_field #(.LO(8'h00), .KEEP(8'h7F)) u_sec (
    .clk(clk), .rst_n(rst_n), .carry_in(sec_tick), .load(wsel[A_SEC]),
    .load_val(wr_data), .limit(8'h59), .value(sec_v), .carry_out(sec_co));

  rtc_bcd_field #(.LO(8'h00), .KEEP(8'h7F)) u_min (
    .clk(clk), .rst_n(rst_n), .carry_in(sec_co), .load(wsel[A_MIN]),
    .load_val(wr_data), .limit(8'h59), .value(min_v), .carry_out(min_co));

  rtc_bcd_field #(.LO(8'h00), .KEEP(8'h3F)) u_hour (
    .clk(clk), .rst_n(rst_n), .carry_in(min_co), .load(wsel[A_HOUR]),
    .load_val(wr_data), .limit(8'h23), .value(hour_v), .carry_out(day_tick));

  rtc_bcd_field #(.LO(8'h01), .KEEP(8'h07)) u_day (
    .clk(clk), .rst_n(rst_n), .carry_in(day_tick), .load(wsel[A_DAY]),
    .load_val(wr_data), .limit(8'h07), .value(day_v), .carry_out(day_co));

  assign date_last = bcd_month_len(mon_v, year_v);

  rtc_bcd_field #(.LO(8'h01), .KEEP(8'h3F)) u_date (
    .clk(clk), .rst_n(rst_n), .carry_in(day_tick), .load(wsel[A_DATE]),
    .load_val(wr_data), .limit(date_last), .value(date_v), .carry_out(date_co));

  rtc_bcd_field #(.LO(8'h01), .KEEP(8'h1F)) u_mon (
    .clk(clk), .rst_n(rst_n), .carry_in(date_co), .load(wsel[A_MON]),
    .load_val(wr_data), .limit(8'h12), .value(mon_v), .carry_out(mon_co));

  rtc_bcd_field #(.LO(8'h00), .KEEP(8'hFF)) u_year (
    .clk(clk), .rst_n(rst_n), .carry_in(mon_co), .load(wsel[A_YEAR]),
    .load_val(wr_data), .limit(8'h99), .value(year_v), .carry_out(year_co));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            century_q <= 1'b0;
    else if (wsel[A_HOUR]) century_q <= wr_data[7];
    else if (year_co)      century_q <= ~century_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ctrl_q <= '0;
    else if (wsel[A_CTRL]) ctrl_q <= wr_data;
  end

  always_comb begin
    case (rd_addr)
      A_SEC:   rd_data = sec_v;
      A_MIN:   rd_data = min_v;
      A_HOUR:  rd_data = {century_q, 1'b0, hour_v[5:0]};
      A_DAY:   rd_data = day_v;
      A_DATE:  rd_data = date_v;
      A_MON:   rd_data = mon_v;
      A_YEAR:  rd_data = year_v;
      default: rd_data = ctrl_q;
    endcase
  end

  p_century_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (year_co && !wsel[A_HOUR]) |=> (century_q != $past(century_q)));
  p_century_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!year_co && !wsel[A_HOUR]) |=> $stable(century_q));
  p_date_wraps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (date_co && !wsel[A_DATE]) |=> (date_v == 8'h01));
  p_ctrl_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wsel[A_CTRL] |=> $stable(ctrl_q));
  p_chain_same_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_co && !wsel[A_MON] && !wsel[A_DATE]) |=> (mon_v == 8'h01 && date_v == 8'h01));
  p_hour_bit6_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hour_v[7:6] == 2'b00);

endmodule

// File: tb/sim_rtc_bcd_core.sv
module sim_rtc_bcd_core;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;

  rtc_bcd_core #(.PRESCALE(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    rd_addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s addr %0d actual %02h expected %02h", req, a, rd_data, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    @(negedge clk);
    osc_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    osc_en = 1'b0;
  endtask

  // Load a full time; seconds go last so the divider restarts.
  task automatic load_all(input logic [7:0] hr, input logic [7:0] mi, input logic [7:0] se,
                          input logic [7:0] dy, input logic [7:0] dt, input logic [7:0] mo,
                          input logic [7:0] yr);
    wr(3'd2, hr); wr(3'd1, mi); wr(3'd3, dy); wr(3'd6, yr);
    wr(3'd5, mo); wr(3'd4, dt); wr(3'd0, se);
  endtask

  task automatic t_reset_r11;
    chk("R11", 3'd0, 8'h00); chk("R11", 3'd1, 8'h00); chk("R11", 3'd2, 8'h00);
    chk("R11", 3'd3, 8'h01); chk("R11", 3'd4, 8'h01); chk("R11", 3'd5, 8'h01);
    chk("R11", 3'd6, 8'h00); chk("R11", 3'd7, 8'h00);
  endtask

  task automatic t_divider_r1;
    wr(3'd0, 8'h00);
    pulses(DIV - 1);
    chk("R1", 3'd0, 8'h00);
    repeat (6) @(negedge clk);
    chk("R1", 3'd0, 8'h00);
    pulses(1);
    chk("R1", 3'd0, 8'h01);
  endtask

  task automatic t_sec_min_r2;
    wr(3'd1, 8'h09); wr(3'd0, 8'h09);
    pulses(DIV);
    chk("R2", 3'd0, 8'h10);
    wr(3'd0, 8'h59);
    pulses(DIV);
    chk("R2", 3'd0, 8'h00);
    chk("R2", 3'd1, 8'h10);
  endtask

  task automatic t_hours_day_r3_r4;
    wr(3'd2, 8'h63);
    chk("R3", 3'd2, 8'h23);
    load_all(8'h23, 8'h59, 8'h59, 8'h07, 8'h15, 8'h06, 8'h10);
    pulses(DIV);
    chk("R3", 3'd2, 8'h00);
    chk("R4", 3'd3, 8'h01);
    chk("R3", 3'd4, 8'h16);
    load_all(8'h09, 8'h59, 8'h59, 8'h02, 8'h15, 8'h06, 8'h10);
    pulses(DIV);
    chk("R3", 3'd2, 8'h10);
    chk("R4", 3'd3, 8'h02);
  endtask

  task automatic t_month_r5;
    load_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h04, 8'h21);
    pulses(DIV);
    chk("R5", 3'd4, 8'h01); chk("R5", 3'd5, 8'h05);
    load_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h05, 8'h21);
    pulses(DIV);
    chk("R5", 3'd4, 8'h31); chk("R5", 3'd5, 8'h05);
    load_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h31, 8'h12, 8'h24);
    pulses(DIV);
    chk("R5", 3'd4, 8'h01); chk("R5", 3'd5, 8'h01); chk("R5", 3'd6, 8'h25);
  endtask

  task automatic t_leap_r6;
    load_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h24);
    pulses(DIV);
    chk("R6", 3'd4, 8'h29); chk("R6", 3'd5, 8'h02);
    load_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h29, 8'h02, 8'h24);
    pulses(DIV);
    chk("R6", 3'd4, 8'h01); chk("R6", 3'd5, 8'h03);
    load_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h23);
    pulses(DIV);
    chk("R6", 3'd4, 8'h01); chk("R6", 3'd5, 8'h03);
    load_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h00);
    pulses(DIV);
    chk("R6", 3'd4, 8'h29);
    load_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h18);
    pulses(DIV);
    chk("R6", 3'd4, 8'h01);
  endtask

  task automatic t_century_r7_r12;
    load_all(8'h23, 8'h59, 8'h59, 8'h03, 8'h31, 8'h12, 8'h99);
    pulses(DIV);
    chk("R12", 3'd0, 8'h00); chk("R12", 3'd1, 8'h00);
    chk("R7", 3'd2, 8'h80);  chk("R12", 3'd3, 8'h04);
    chk("R12", 3'd4, 8'h01); chk("R12", 3'd5, 8'h01);
    chk("R7", 3'd6, 8'h00);
    load_all(8'hA3, 8'h59, 8'h59, 8'h03, 8'h31, 8'h12, 8'h99);
    chk("R7", 3'd2, 8'hA3);
    pulses(DIV);
    chk("R7", 3'd2, 8'h00);
  endtask

  task automatic t_ctrl_r8;
    wr(3'd7, 8'h5A);
    chk("R8", 3'd7, 8'h5A);
    wr(3'd0, 8'h59);
    pulses(DIV);
    chk("R8", 3'd7, 8'h5A);
    chk("R8", 3'd0, 8'h00);
  endtask

  task automatic t_collide_r9;
    load_all(8'h05, 8'h10, 8'h59, 8'h01, 8'h10, 8'h03, 8'h30);
    @(negedge clk);
    osc_en = 1'b1;
    repeat (DIV - 1) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h33;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; osc_en = 1'b0;
    chk("R9", 3'd1, 8'h33);
    chk("R9", 3'd0, 8'h00);
    chk("R9", 3'd2, 8'h05);
  endtask

  task automatic t_restart_r10;
    wr(3'd0, 8'h00);
    pulses(DIV - 2);
    @(negedge clk);
    osc_en = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h20;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; osc_en = 1'b0;
    chk("R10", 3'd0, 8'h20);
    pulses(DIV - 1);
    chk("R10", 3'd0, 8'h20);
    pulses(1);
    chk("R10", 3'd0, 8'h21);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_r11();
    t_divider_r1();
    t_sec_min_r2();
    t_hours_day_r3_r4();
    t_month_r5();
    t_leap_r6();
    t_century_r7_r12();
    t_ctrl_r8();
    t_collide_r9();
    t_restart_r10();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule